// File: doc/BRIEF.md
# Accumulator Rounding Unit with Selectable Tie Handling

This block rounds a 40-bit multiply-accumulate result to its upper 24 bits. The accumulator value is viewed as an 8-bit top byte, a 16-bit upper word and a 16-bit lower word. Rounding adds one half of an upper-word unit at the boundary between the lower and the upper word. Any carry ripples up through the upper word and into the top byte.

A tie occurs when the lower word is exactly 0x8000. A mode bit decides how a tie is resolved. With the mode bit clear, the tie rounds to even: the upper word ends with its least significant bit cleared. With the mode bit set, the tie always rounds up. For every other lower-word value the two modes give the same result. The mode bit is held in a 16-bit control register that a bus master writes and reads.

A caller raises a round request together with the accumulator value. One clock later the block returns the rounded value with a valid strobe. A new request may be issued on every cycle.

Top module: `acc_round_top`

## Requirements
- R1: After reset, `accValid` is 0 and `ctrlRdData` reads 0x0000, which selects round-to-even mode.
- R2: `accValid` is 1 exactly in the cycle after a cycle in which `roundReq` was 1, and 0 otherwise.
- R3: When the lower word (bits 15:0) is above 0x8000, result bits 39:16 equal input bits 39:16 plus one.
- R4: When the lower word is below 0x8000, result bits 39:16 equal input bits 39:16.
- R5: When the lower word is exactly 0x8000 and the mode bit is 0, an odd upper word (bit 16 = 1) is incremented and an even one is left unchanged. For example, 00-0000-8000 gives 00-0000-8000 and 00-0001-8000 gives 00-0002-8000.
- R6: When the lower word is exactly 0x8000 and the mode bit is 1, bits 39:16 are always incremented. For example, 00-0000-8000 gives 00-0001-8000.
- R7: Result bits 15:0 always equal input bits 15:0.
- R8: A carry out of the upper word enters the top byte (00-FFFF-8001 gives 01-0000-8001). An increment of FF-FFFF wraps to 00-0000 and is not flagged.
- R9: The mode bit is bit 12 of the control register. A write sets all 16 bits, and every bit reads back on `ctrlRdData`. A request uses the register value held at the start of its own cycle, so a write in the same cycle affects only later requests.
- R10: When `roundReq` is 0, `accOut` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| roundReq | input | 1 | Round request for `accIn` |
| accIn | input | 40 | Accumulator value to round |
| ctrlWrEn | input | 1 | Control register write enable |
| ctrlWrData | input | 16 | Control register write data (bit 12 = tie mode) |
| ctrlRdData | output | 16 | Control register contents |
| accOut | output | 40 | Rounded accumulator value |
| accValid | output | 1 | Result valid, one cycle after the request |

## Verification
Every rounded result and its valid strobe appear one clock edge after the request is sampled. The bench drives on the falling edge. It checks the response on the next falling edge, before it drives the next request, so back-to-back streams are checked one cycle behind the stimulus.

A control register write is visible on `ctrlRdData` after the same single edge. The bench checks that a write in the same cycle as a request does not change the mode that request uses, and that the new mode applies to the request after it.

// File: rtl/acc_round_pkg.sv
package acc_round_pkg;
  localparam int TOP_W   = 8;
  localparam int WORD_W  = 16;
  localparam int ACC_W   = TOP_W + 2 * WORD_W;
  localparam int CTRL_W  = 16;
  localparam int MODE_BIT = 12;

  typedef struct packed {
    logic capture;
    logic biasMode;
  } roundCtl_t;
endpackage

// File: rtl/acc_round_ctrl.sv
module acc_round_ctrl
  import acc_round_pkg::*;
#(
  parameter int CW   = CTRL_W,
  parameter int MBIT = MODE_BIT
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          roundReq,
  input  logic          ctrlWrEn,
  input  logic [CW-1:0] ctrlWrData,
  output logic [CW-1:0] ctrlRdData,
  output roundCtl_t     ctl
);
  logic [CW-1:0] ctrlReg;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWrEn) ctrlReg <= ctrlWrData;
  end

  assign ctrlRdData = ctrlReg;

  always_comb begin
    ctl.capture  = roundReq;
    ctl.biasMode = ctrlReg[MBIT];
  end
endmodule

// File: rtl/acc_round_dp.sv
module acc_round_dp
  import acc_round_pkg::*;
#(
  parameter int TW = TOP_W,
  parameter int WW = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  roundCtl_t         ctl,
  input  logic [TW+2*WW-1:0] accIn,
  output logic [TW+2*WW-1:0] accOut,
  output logic              accValid
);
  localparam int AW = TW + 2 * WW;
  localparam int UW = TW + WW;
  localparam logic [WW-1:0] HALF = {1'b1, {(WW-1){1'b0}}};

  logic [WW-1:0] lowWord;
  logic [UW-1:0] upperPart;
  logic [UW-1:0] upperRnd;
  logic          isTie;
  logic          atOrAbove;

  assign lowWord   = accIn[WW-1:0];
  assign upperPart = accIn[AW-1:WW];
  assign isTie     = (lowWord == HALF);
  assign atOrAbove = lowWord[WW-1];

  always_comb begin
    upperRnd = upperPart + UW'(atOrAbove);
    if (isTie && !ctl.biasMode) upperRnd[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accOut   <= '0;
      accValid <= 1'b0;
    end else begin
      accValid <= ctl.capture;
      if (ctl.capture) accOut <= {upperRnd, lowWord};
    end
  end
endmodule

// File: rtl/acc_round_top.sv
module acc_round_top
  import acc_round_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              roundReq,
  input  logic [ACC_W-1:0]  accIn,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  output logic [ACC_W-1:0]  accOut,
  output logic              accValid
);
  roundCtl_t ctl;

  acc_round_ctrl #(.CW(CTRL_W), .MBIT(MODE_BIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .roundReq(roundReq),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .ctl(ctl)
  );

  acc_round_dp #(.TW(TOP_W), .WW(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .accIn(accIn),
    .accOut(accOut), .accValid(accValid)
  );
endmodule

// File: rtl/acc_round_checker.sv
module acc_round_checker
  import acc_round_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              roundReq,
  input logic [ACC_W-1:0]  accIn,
  input logic              ctrlWrEn,
  input logic [CTRL_W-1:0] ctrlWrData,
  input logic [CTRL_W-1:0] ctrlRdData,
  input logic [ACC_W-1:0]  accOut,
  input logic              accValid
);
  localparam int UW = TOP_W + WORD_W;
  localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rstN)
    roundReq |=> accValid);
  a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !roundReq |=> !accValid);
  a_r3_above_half: assert property (@(posedge clk) disable iff (!rstN)
    (roundReq && accIn[WORD_W-1:0] > HALF) |=>
      accOut[ACC_W-1:WORD_W] == UW'($past(accIn[ACC_W-1:WORD_W]) + 1'b1));
  a_r4_below_half: assert property (@(posedge clk) disable iff (!rstN)
    (roundReq && accIn[WORD_W-1:0] < HALF) |=>
      accOut[ACC_W-1:WORD_W] == $past(accIn[ACC_W-1:WORD_W]));
  a_r5_tie_even_result: assert property (@(posedge clk) disable iff (!rstN)
    (roundReq && accIn[WORD_W-1:0] == HALF && !ctrlRdData[MODE_BIT]) |=>
      !accOut[WORD_W]);
  a_r6_tie_round_up: assert property (@(posedge clk) disable iff (!rstN)
    (roundReq && accIn[WORD_W-1:0] == HALF && ctrlRdData[MODE_BIT]) |=>
      accOut[ACC_W-1:WORD_W] == UW'($past(accIn[ACC_W-1:WORD_W]) + 1'b1));
  a_r7_low_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    roundReq |=> accOut[WORD_W-1:0] == $past(accIn[WORD_W-1:0]));
  a_r9_ctrl_write: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> ctrlRdData == $past(ctrlWrData));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !roundReq |=> $stable(accOut));
endmodule

bind acc_round_top acc_round_checker i_checker (
  .clk(clk), .rstN(rstN), .roundReq(roundReq), .accIn(accIn),
  .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
  .accOut(accOut), .accValid(accValid)
);

// File: tb/test_acc_round_top.sv
module test_acc_round_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        roundReq = 1'b0;
  logic [39:0] accIn = '0;
  logic        ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic [15:0] ctrlRdData;
  logic [39:0] accOut;
  logic        accValid;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  acc_round_top i_acc_round_top (
    .clk(clk), .rstN(rstN), .roundReq(roundReq), .accIn(accIn),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .accOut(accOut), .accValid(accValid)
  );

  function automatic logic [39:0] refRound(input logic [39:0] a, input logic bias);
    logic [23:0] up;
    up = a[39:16];
    if (a[15:0] > 16'h8000) up = up + 24'd1;
    else if (a[15:0] == 16'h8000) begin
      if (bias || up[0]) up = up + 24'd1;
    end
    return {up, a[15:0]};
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [15:0] d);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = d;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic roundOne(input string req, input logic [39:0] a, input logic [39:0] exp);
    @(negedge clk);
    roundReq = 1'b1; accIn = a;
    @(negedge clk);
    roundReq = 1'b0;
    check(req, {39'd0, accValid}, 40'd1);
    check(req, accOut, exp);
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [39:0] prevExp;
    logic        prevOn;
    logic [39:0] heldOut;
    logic        mode;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {39'd0, accValid}, 40'd0);
    check("R1", {24'd0, ctrlRdData}, 40'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", {39'd0, accValid}, 40'd0);

    // Directed cases, round-to-even mode
    roundOne("R5", 40'h00_0000_8000, 40'h00_0000_8000);
    roundOne("R5", 40'h00_0001_8000, 40'h00_0002_8000);
    roundOne("R3", 40'h00_0000_8001, 40'h00_0001_8001);
    roundOne("R4", 40'h00_0000_7FFF, 40'h00_0000_7FFF);
    roundOne("R7", 40'h12_3456_ABCD, 40'h12_3457_ABCD);
    roundOne("R8", 40'h00_FFFF_8001, 40'h01_0000_8001);
    roundOne("R8", 40'hFF_FFFF_C000, 40'h00_0000_C000);
    roundOne("R5", 40'hFF_FFFF_8000, 40'h00_0000_8000);
    heldOut = accOut;
    @(negedge clk);
    check("R10", accOut, heldOut);
    check("R2", {39'd0, accValid}, 40'd0);

    // R9 register storage and mode bit position
    writeCtrl(16'hEFFF);
    check("R9", {24'd0, ctrlRdData}, {24'd0, 16'hEFFF});
    roundOne("R9", 40'h00_0000_8000, 40'h00_0000_8000);
    writeCtrl(16'h1000);
    check("R9", {24'd0, ctrlRdData}, {24'd0, 16'h1000});
    roundOne("R6", 40'h00_0000_8000, 40'h00_0001_8000);
    roundOne("R6", 40'h00_0001_8000, 40'h00_0002_8000);
    roundOne("R6", 40'hFF_FFFF_8000, 40'h00_0000_8000);
    roundOne("R4", 40'h00_0001_7FFF, 40'h00_0001_7FFF);

    // R9 write in the same cycle as a request: old mode applies
    @(negedge clk);
    roundReq = 1'b1; accIn = 40'h00_0010_8000;
    ctrlWrEn = 1'b1; ctrlWrData = 16'h0000;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    accIn = 40'h00_0020_8000;
    check("R9", accOut, 40'h00_0011_8000);
    @(negedge clk);
    roundReq = 1'b0;
    check("R9", accOut, 40'h00_0020_8000);

    // R10 back-to-back random stream with mode changes
    prevOn = 1'b0; prevExp = '0; mode = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic [39:0] a;
      logic        req;
      @(negedge clk);
      if (prevOn) check("R10", accOut, prevExp);
      check("R2", {39'd0, accValid}, {39'd0, prevOn});
      if (i % 50 == 49) begin
        mode = ~mode;
        ctrlWrEn = 1'b1; ctrlWrData = {3'b0, mode, 12'h0};
        roundReq = 1'b0;
        prevOn = 1'b0;
        continue;
      end
      ctrlWrEn = 1'b0;
      a = {$urandom(), $urandom()} ;
      if ($urandom_range(0, 3) == 0) a[15:0] = 16'h8000;
      if ($urandom_range(0, 9) == 0) a[39:16] = 24'hFFFFFF;
      req = ($urandom_range(0, 4) != 0);
      roundReq = req; accIn = a;
      if (req) prevExp = refRound(a, mode);
      prevOn = req;
    end
    @(negedge clk);
    ctrlWrEn = 1'b0; roundReq = 1'b0;
    if (prevOn) check("R10", accOut, prevExp);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule